// File: doc/BRIEF.md
# Tiled 24-bit Significand Multiplier

This block multiplies two 24-bit unsigned significands and returns the full 48-bit product, plus a 24-bit significand rounded to nearest with ties to even. The product is built from nine 8x8 multiplier tiles, one for each pair of operand bytes. Each tile gives a 16-bit partial product. The partial products are aligned by byte weight and compressed in a single layer of (5,5,4) parallel counters. A counter takes five bits from each of two adjacent columns and returns their weighted 4-bit count.

The two rows that the counters leave are summed by a hierarchical carry-lookahead adder. Its 4-bit adder cells pass group propagate and generate signals to two levels of 4-bit lookahead units, which return the carries.

The rounding stage normalizes on product bit 47, keeps 24 bits and rounds them. If rounding up carries out of the kept field, it flags the result and shifts it right by one. The datapath is purely combinational, so it can be placed in any pipeline that surrounds it. Exponent, sign and exceptions belong to the surrounding floating-point unit.

Top module: `sigmul`

## Requirements
- R1: `prod_o` equals the exact 48-bit unsigned product `a_i * b_i` for every pair of 24-bit inputs.
- R2: The tile product of byte i of `a_i` and byte j of `b_i` (byte 0 = bits 7:0) contributes at weight 2^(8(i+j)). Single-byte operands placed in any byte lane give the exact product.
- R3: The worst column load gives the exact product: all-ones operands give 0xFFFFFE000001, and all-ones times one gives 0xFFFFFF.
- R4: Carries propagate correctly across all twelve 4-bit adder groups, for example 0x800001 * 0xFFFFFF = 0x8000007FFFFF.
- R5: `norm_o` equals `prod_o[47]`.
- R6: With `norm_o`=1 the kept field is `prod_o[47:24]`, guard is bit 23, round is bit 22 and sticky is the OR of bits 21:0. With `norm_o`=0 the kept field is `prod_o[46:23]`, guard is bit 22, round is bit 21 and sticky is the OR of bits 20:0. With guard 0, `sig_o` equals the kept field.
- R7: With guard 1 and round or sticky 1, `sig_o` equals the kept field plus one.
- R8: With guard 1 and round and sticky both 0 (a tie), the kept field is incremented only if its bit 0 is 1.
- R9: If the increment overflows 24 bits, `renorm_o` is 1 and `sig_o` is 0x800000. Otherwise `renorm_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 24 | Significand operand A |
| b_i | input | 24 | Significand operand B |
| prod_o | output | 48 | Full unsigned product |
| sig_o | output | 24 | Normalized, rounded significand |
| norm_o | output | 1 | Product bit 47 was set; rounding started there |
| renorm_o | output | 1 | Rounding overflowed and the result was shifted right by one |

## Verification
The checks on the rounded field's leading one assume that both operands have bit 23 set, as normalized significands do. Those checks fire only when both inputs meet that condition. The checks on the counter spill and the adder carry-out rely on nothing but the 24-bit operand width. The random stimulus sets both leading bits for most vectors and leaves them free for the rest. The free vectors exercise the product and rounding rules, which hold for any input, without triggering the normalized-input checks. The rounding-overflow operand pair is found by a bounded arithmetic search over normalized operands.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;
  // widths of the library tile and the counter fan-in
  localparam int unsigned TILE_W = 8;
  localparam int unsigned CNT_H  = 5;
  localparam int unsigned CNT_W  = 4;

  function automatic logic [2:0] ones5(input logic [CNT_H-1:0] v);
    logic [2:0] n;
    n = '0;
    for (int k = 0; k < CNT_H; k++) n = n + {2'b00, v[k]};
    return n;
  endfunction
endpackage

// File: rtl/sigmul_tile.sv
module sigmul_tile #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  // library multiplier cell model
  assign p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
endmodule

// File: rtl/sigmul_cnt554.sv
module sigmul_cnt554
  import sigmul_pkg::*;
(
  input  logic [CNT_H-1:0] lo_i,
  input  logic [CNT_H-1:0] hi_i,
  output logic [CNT_W-1:0] s_o
);
  logic [2:0] n_lo, n_hi;
  assign n_lo = ones5(lo_i);
  assign n_hi = ones5(hi_i);
  assign s_o  = {1'b0, n_lo} + {n_hi, 1'b0};
endmodule

// File: rtl/sigmul_reduce.sv
module sigmul_reduce
  import sigmul_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned N  = 3,
  localparam int unsigned PW = 2*N*W,
  localparam int unsigned NT = N*N,
  localparam int unsigned NP = PW/2
) (
  input  logic [NT*2*W-1:0] pp_i,
  output logic [PW-1:0]     row0_o,
  output logic [PW-1:0]     row1_o
);
  logic [CNT_H-1:0] col [PW];
  logic [CNT_W-1:0] cs  [NP];
  logic             col_ovf;
  logic [1:0]       spill;

  // stack every tile bit into its column at weight 8(i+j)
  always_comb begin
    int fill [PW];
    int base, c;
    col_ovf = 1'b0;
    for (int k = 0; k < int'(PW); k++) begin
      col[k]  = '0;
      fill[k] = 0;
    end
    for (int t = 0; t < int'(NT); t++) begin
      base = int'(W) * (t / int'(N) + t % int'(N));
      for (int b = 0; b < 2*int'(W); b++) begin
        c = base + b;
        if (fill[c] < int'(CNT_H)) col[c][fill[c]] = pp_i[t*2*int'(W) + b];
        else col_ovf = 1'b1;
        fill[c] = fill[c] + 1;
      end
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_cnt
    sigmul_cnt554 u_cnt (
      .lo_i (col[2*k]),
      .hi_i (col[2*k+1]),
      .s_o  (cs[k])
    );
  end

  always_comb begin
    row0_o = '0;
    row1_o = '0;
    spill  = '0;
    for (int k = 0; k < int'(NP); k++) begin
      row0_o[2*k]   = cs[k][0];
      row0_o[2*k+1] = cs[k][1];
      if (k < int'(NP) - 1) begin
        row1_o[2*k+2] = cs[k][2];
        row1_o[2*k+3] = cs[k][3];
      end else begin
        spill = cs[k][3:2];
      end
    end
  end

  // R3
  always_comb col_height_chk: assert (!col_ovf);
  // R1
  always_comb cnt_spill_chk: assert (spill == 2'b00);
endmodule

// File: rtl/sigmul_add4.sv
module sigmul_add4 (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       gp_o,
  output logic       gg_o
);
  logic [3:0] p, g, c;
  assign p = a_i ^ b_i;
  assign g = a_i & b_i;
  assign c[0] = c_i;
  assign c[1] = g[0] | (p[0] & c_i);
  assign c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & c_i);
  assign c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0]) | (p[2] & p[1] & p[0] & c_i);
  assign s_o  = p ^ c;
  assign gp_o = &p;
  assign gg_o = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1]) | (p[3] & p[2] & p[1] & g[0]);
endmodule

// File: rtl/sigmul_lcu4.sv
module sigmul_lcu4 (
  input  logic [3:0] p_i,
  input  logic [3:0] g_i,
  input  logic       c_i,
  output logic [3:0] c_o,
  output logic       gp_o,
  output logic       gg_o
);
  assign c_o[0] = c_i;
  assign c_o[1] = g_i[0] | (p_i[0] & c_i);
  assign c_o[2] = g_i[1] | (p_i[1] & g_i[0]) | (p_i[1] & p_i[0] & c_i);
  assign c_o[3] = g_i[2] | (p_i[2] & g_i[1]) | (p_i[2] & p_i[1] & g_i[0])
                | (p_i[2] & p_i[1] & p_i[0] & c_i);
  assign gp_o = &p_i;
  assign gg_o = g_i[3] | (p_i[3] & g_i[2]) | (p_i[3] & p_i[2] & g_i[1])
              | (p_i[3] & p_i[2] & p_i[1] & g_i[0]);
endmodule

// File: rtl/sigmul_cla.sv
module sigmul_cla #(
  parameter int unsigned PW  = 48,
  localparam int unsigned NIB = PW/4,
  localparam int unsigned NL1 = NIB/4
) (
  input  logic [PW-1:0] a_i,
  input  logic [PW-1:0] b_i,
  output logic [PW-1:0] s_o,
  output logic          co_o
);
  logic [NIB-1:0] gp_n, gg_n, cin_n;
  logic [3:0]     p1, g1, c1;
  logic           p2, g2;

  for (genvar n = 0; n < NIB; n++) begin : g_nib
    sigmul_add4 u_add (
      .a_i  (a_i[4*n +: 4]),
      .b_i  (b_i[4*n +: 4]),
      .c_i  (cin_n[n]),
      .s_o  (s_o[4*n +: 4]),
      .gp_o (gp_n[n]),
      .gg_o (gg_n[n])
    );
  end

  for (genvar m = 0; m < 4; m++) begin : g_l1
    if (m < NL1) begin : g_used
      sigmul_lcu4 u_lcu (
        .p_i  (gp_n[4*m +: 4]),
        .g_i  (gg_n[4*m +: 4]),
        .c_i  (c1[m]),
        .c_o  (cin_n[4*m +: 4]),
        .gp_o (p1[m]),
        .gg_o (g1[m])
      );
    end else begin : g_pad
      assign p1[m] = 1'b0;
      assign g1[m] = 1'b0;
    end
  end

  sigmul_lcu4 u_lcu_top (
    .p_i  (p1),
    .g_i  (g1),
    .c_i  (1'b0),
    .c_o  (c1),
    .gp_o (p2),
    .gg_o (g2)
  );

  if (NL1 < 4) begin : g_co_mid
    assign co_o = c1[NL1];
  end else begin : g_co_top
    assign co_o = g2;
  end

  logic unused_p2;
  assign unused_p2 = p2;
endmodule

// File: rtl/sigmul_round.sv
module sigmul_round #(
  parameter int unsigned OPW    = 24,
  parameter bit          RND_EN = 1'b1,
  localparam int unsigned PW    = 2*OPW
) (
  input  logic [PW-1:0]  prod_i,
  output logic [OPW-1:0] sig_o,
  output logic           norm_o,
  output logic           renorm_o
);
  logic [OPW-1:0] keep;
  logic           grd, rnd, stk;
  logic [OPW:0]   inc;

  assign norm_o = prod_i[PW-1];

  always_comb begin
    if (norm_o) begin
      keep = prod_i[PW-1 -: OPW];
      grd  = prod_i[OPW-1];
      rnd  = prod_i[OPW-2];
      stk  = |prod_i[OPW-3:0];
    end else begin
      keep = prod_i[PW-2 -: OPW];
      grd  = prod_i[OPW-2];
      rnd  = prod_i[OPW-3];
      stk  = |prod_i[OPW-4:0];
    end
  end

  if (RND_EN) begin : g_rne
    logic up;
    assign up       = grd & (rnd | stk | keep[0]);
    assign inc      = {1'b0, keep} + {{OPW{1'b0}}, up};
    assign renorm_o = inc[OPW];
    assign sig_o    = inc[OPW] ? inc[OPW:1] : inc[OPW-1:0];
  end else begin : g_trunc
    assign inc      = '0;
    assign renorm_o = 1'b0;
    assign sig_o    = keep;
  end

  logic unused_rnd;
  assign unused_rnd = ^{inc, rnd, stk};

  // R9
  always_comb renorm_value_chk: assert (!renorm_o || sig_o == {1'b1, {(OPW-1){1'b0}}});
endmodule

// File: rtl/sigmul.sv
module sigmul #(
  parameter int unsigned W      = 8,
  parameter int unsigned N      = 3,
  parameter bit          RND_EN = 1'b1,
  localparam int unsigned OPW   = N*W,
  localparam int unsigned PW    = 2*OPW,
  localparam int unsigned NT    = N*N
) (
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic [PW-1:0]  prod_o,
  output logic [OPW-1:0] sig_o,
  output logic           norm_o,
  output logic           renorm_o
);
  logic [NT*2*W-1:0] pp;
  logic [PW-1:0]     row0, row1;
  logic              co;

  for (genvar i = 0; i < N; i++) begin : g_ra
    for (genvar j = 0; j < N; j++) begin : g_rb
      sigmul_tile #(.W(W)) u_tile (
        .a_i (a_i[i*W +: W]),
        .b_i (b_i[j*W +: W]),
        .p_o (pp[(i*N+j)*2*W +: 2*W])
      );
    end
  end

  sigmul_reduce #(.W(W), .N(N)) u_red (
    .pp_i   (pp),
    .row0_o (row0),
    .row1_o (row1)
  );

  sigmul_cla #(.PW(PW)) u_cla (
    .a_i  (row0),
    .b_i  (row1),
    .s_o  (prod_o),
    .co_o (co)
  );

  sigmul_round #(.OPW(OPW), .RND_EN(RND_EN)) u_rnd (
    .prod_i   (prod_o),
    .sig_o    (sig_o),
    .norm_o   (norm_o),
    .renorm_o (renorm_o)
  );

  // R1
  always_comb cla_carry_chk: assert (!co);
  // R6
  always_comb norm_lead_chk: assert (!(a_i[OPW-1] && b_i[OPW-1]) || prod_o[PW-1] || prod_o[PW-2]);
  // R6
  always_comb sig_lead_chk: assert (!(a_i[OPW-1] && b_i[OPW-1]) || sig_o[OPW-1]);
endmodule

// File: tb/tb_sigmul.sv
module tb_sigmul;
  logic        clk;
  logic [23:0] a_i, b_i;
  logic [47:0] prod_o;
  logic [23:0] sig_o;
  logic        norm_o, renorm_o;
  int          n_chk, n_bad;
  bit          done;

  sigmul dut (
    .a_i      (a_i),
    .b_i      (b_i),
    .prod_o   (prod_o),
    .sig_o    (sig_o),
    .norm_o   (norm_o),
    .renorm_o (renorm_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // operand pairs {a, b}
  localparam logic [47:0] VEC [16] = '{
    {24'h800000, 24'h800000}, {24'hFFFFFF, 24'hFFFFFF},
    {24'hFFFFFF, 24'h000001}, {24'h800001, 24'hFFFFFF},
    {24'hC00000, 24'h800001}, {24'hC00000, 24'h800003},
    {24'hB504F3, 24'hB504F3}, {24'hAAAAAA, 24'h555555},
    {24'h123456, 24'h789ABC}, {24'hFFFFFE, 24'hFFFFFD},
    {24'h000000, 24'hFFFFFF}, {24'h00FF00, 24'hFF00FF},
    {24'h800000, 24'hFFFFFF}, {24'hA00001, 24'hD00007},
    {24'hF0F0F0, 24'h0F0F0F}, {24'hC90FDB, 24'hADF854}
  };

  // {renorm, norm, sig} from the rounding requirements
  function automatic logic [25:0] ref_rnd(input logic [47:0] p);
    logic [23:0] kp;
    logic        g, r, s, up;
    logic [24:0] sm;
    if (p[47]) begin kp = p[47:24]; g = p[23]; r = p[22]; s = |p[21:0]; end
    else       begin kp = p[46:23]; g = p[22]; r = p[21]; s = |p[20:0]; end
    up = g & (r | s | kp[0]);
    sm = {1'b0, kp} + {24'd0, up};
    return {sm[24], p[47], sm[24] ? sm[24:1] : sm[23:0]};
  endfunction

  task automatic apply(input logic [23:0] a, input logic [23:0] b, input string tag);
    logic [47:0] ep;
    logic [25:0] er;
    ep = 48'({24'd0, a} * {24'd0, b});
    er = ref_rnd(ep);
    a_i = a;
    b_i = b;
    @(negedge clk);
    n_chk++;
    if (prod_o !== ep || sig_o !== er[23:0] || norm_o !== er[24] || renorm_o !== er[25]) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h prod=%h/%h sig=%h/%h norm=%b/%b renorm=%b/%b",
               tag, a, b, prod_o, ep, sig_o, er[23:0], norm_o, er[24], renorm_o, er[25]);
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    a_i = '0; b_i = '0;
    @(negedge clk);
    // idle state with zero operands: R1
    n_chk++;
    if (prod_o !== '0 || sig_o !== '0 || norm_o !== 1'b0 || renorm_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 zero operands prod=%h sig=%h exp 0", prod_o, sig_o);
    end

    for (int k = 0; k < 16; k++) apply(VEC[k][47:24], VEC[k][23:0], "R1 table");

    // R2 byte lane placement
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        apply(24'(24'hAB << (8*i)), 24'(24'hCD << (8*j)), "R2");

    // R3 full column load
    apply(24'hFFFFFF, 24'hFFFFFF, "R3");
    apply(24'hFFFFFF, 24'h000001, "R3");
    // R4 long carry
    apply(24'h800001, 24'hFFFFFF, "R4");
    n_chk++;
    if (prod_o !== 48'h8000007FFFFF) begin
      n_bad++;
      $display("FAIL R4 prod=%h exp 8000007fffff", prod_o);
    end
    // R5 normalization bit
    apply(24'h800000, 24'h800000, "R5");
    n_chk++;
    if (norm_o !== 1'b0 || sig_o !== 24'h800000) begin
      n_bad++;
      $display("FAIL R5 norm=%b sig=%h exp 0 800000", norm_o, sig_o);
    end
    // R6 guard clear: truncate
    apply(24'h800000, 24'hFFFFFF, "R6");
    // R7 guard and sticky
    apply(24'hA00001, 24'hD00007, "R7");
    // R8 tie, odd kept field: round up
    apply(24'hC00000, 24'h800001, "R8");
    n_chk++;
    if (sig_o !== 24'hC00002) begin
      n_bad++;
      $display("FAIL R8 odd tie sig=%h exp c00002", sig_o);
    end
    // R8 tie, even kept field: stay
    apply(24'hC00000, 24'h800003, "R8");
    n_chk++;
    if (sig_o !== 24'hC00004) begin
      n_bad++;
      $display("FAIL R8 even tie sig=%h exp c00004", sig_o);
    end

    // R9 search for a product whose rounding overflows
    begin
      bit found;
      logic [63:0] t, av, bv;
      found = 1'b0;
      t = 64'h0000_8000_0000_0000 - 64'h40_0000;
      for (int k = 0; k < 4096 && !found; k++) begin
        av = 64'hB504F4 + 64'(k);
        bv = (t + av - 1) / av;
        if (bv < 64'h100_0000 && av * bv < 64'h0000_8000_0000_0000) begin
          found = 1'b1;
          apply(av[23:0], bv[23:0], "R9");
          n_chk++;
          if (renorm_o !== 1'b1 || sig_o !== 24'h800000) begin
            n_bad++;
            $display("FAIL R9 renorm=%b sig=%h exp 1 800000", renorm_o, sig_o);
          end
        end
      end
      n_chk++;
      if (!found) begin
        n_bad++;
        $display("FAIL R9 no overflow operand pair found act 0 exp 1");
      end
    end

    // random: normalized mostly, free otherwise
    for (int k = 0; k < 400; k++) begin
      logic [23:0] ra, rb;
      ra = 24'($urandom);
      rb = 24'($urandom);
      if (k % 4 != 3) begin ra[23] = 1'b1; rb[23] = 1'b1; end
      apply(ra, rb, "R1 R7 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act hung exp done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule